// File: doc/BRIEF.md
# Banked Interrupt Distributor Register File

This block collects interrupt requests from peripherals and from software and decides which of them each processor port should see. Every interrupt has enable, pending and active state bits, a trigger mode, an 8-bit priority and, for shared interrupts, a per-CPU routing byte. Software reaches all of it over a simple word-addressed register bus. That bus carries the number of the requesting CPU beside the address, and the number selects the private bank for interrupt IDs 0 to 31.

IDs 0 to 15 have no input line and can be raised only by a write to the pending set view. IDs 16 to 31 have one input line per CPU. IDs 32 and up share one input line each and are routed by their target byte. Each CPU port carries the registered vector of interrupts that are pending, enabled and routed to that CPU. A control bit gates the whole vector. Priorities are stored and exported unchanged for a downstream arbiter.

Top module: `irqdist_top`

## Requirements
- R1: Enable, pending and active each have a set view and a clear view. The word addresses are enable 0x020/0x040, pending 0x060/0x080 and active 0x0A0/0x0C0 (set/clear), plus word w. ID n sits at word n/32, bit n%32. Either view reads the current state. A 1 written to the set view sets the bit, and a 1 written to the clear view clears it.
- R2: A 0 written to any bit of a set or clear view leaves that bit unchanged.
- R3: For IDs 0–31, the enable, pending, active and configuration state is held once per CPU. The bank is chosen by `bus_cpu` on each access and by the local line index for hardware requests.
- R4: The target area starts at 0x200. Each ID has one byte, with ID n in word n/4, byte lane n%4, and bit c of the byte stands for CPU c. Only the low NUM_CPU bits are stored, and the upper bits read 0. A shared interrupt reaches CPU c only when its target bit c is set.
- R5: Target bytes for IDs 0–31 ignore writes and read back the one-hot bit of the accessing CPU.
- R6: The configuration area starts at 0x300 with 2 bits per ID. ID n uses word n/16, and bit 2*(n%16)+1 is 1 for rising edge and 0 for level high. The even bits read 0. Word 0 (IDs 0–15) always reads 0xAAAAAAAA and ignores writes. Word 1 is banked per CPU.
- R7: Word 0x001 reads NUM_IRQ/32−1 in bits 4:0.
- R8: The priority area starts at 0x100 with one byte per ID at word n/4, lane n%4. Each byte is read back and exported on `prio_o[8n+7:8n]`.
- R9: While bit 0 of word 0x000 is 0, every `cpu_irq` bit is 0 one cycle later. Reset clears it.
- R10: In edge mode, a rising edge on the line sets pending once. A clear issued while the line stays high leaves pending clear.
- R11: In level mode, pending is set in every cycle the line is high, so a clear has no effect until the line is low.
- R12: `cpu_irq[c*NUM_IRQ+n]` is 1 one cycle after ID n is pending and enabled in CPU c's view (and routed to c, for n ≥ 32) with forwarding on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 3 | Number of the accessing CPU |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_shared | input | NUM_IRQ-32 | Lines for IDs 32 and up, bit j = ID 32+j |
| irq_local | input | NUM_CPU*16 | Per-CPU lines for IDs 16–31, bit 16c+k = ID 16+k of CPU c |
| cpu_irq | output | NUM_CPU*NUM_IRQ | Forwarded interrupts per CPU |
| prio_o | output | NUM_IRQ*8 | Priority byte of every ID |

## Verification
The hardest case to reach is a software clear that arrives while a level line is still high, and the same clear on an edge-mode line that stays high. Only the trigger mode decides whether the clear holds. The stimulus first programs the mode bits through the configuration words. It then parks a line high, clears through the clear view and reads back. After that it drops the line and clears again. Banking is exercised by the same addresses issued under two CPU numbers, with the result read back under each number.

// File: rtl/irqdist_pkg.sv
package irqdist_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int CPU_ID_W = 3;

  typedef enum logic [1:0] {
    AREA_BITS = 2'd0,
    AREA_PRIO = 2'd1,
    AREA_TGT  = 2'd2,
    AREA_CFG  = 2'd3
  } area_e;

  typedef enum logic [2:0] {
    VW_MISC   = 3'd0,
    VW_EN_SET = 3'd1,
    VW_EN_CLR = 3'd2,
    VW_PD_SET = 3'd3,
    VW_PD_CLR = 3'd4,
    VW_AC_SET = 3'd5,
    VW_AC_CLR = 3'd6,
    VW_NONE   = 3'd7
  } view_e;

  localparam logic [DATA_W-1:0] CFG_FIXED_WORD = 32'hAAAA_AAAA;

  // place sixteen edge flags on the odd bit of each 2-bit config field
  function automatic logic [DATA_W-1:0] spread_edge(input logic [15:0] e);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < 16; k++) begin
      r[2*k]   = 1'b0;
      r[2*k+1] = e[k];
    end
    return r;
  endfunction
endpackage

// File: rtl/irqdist_bits.sv
module irqdist_bits #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_i) | set_i;
  end

  p_set_takes_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~q & $past(set_i)) == '0));
  p_clear_takes_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irqdist_route.sv
module irqdist_route #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         glob_en,
  input  logic [NUM_CPU*NUM_IRQ-1:0]   pend_all,
  input  logic [NUM_CPU*NUM_IRQ-1:0]   en_all,
  input  logic [(NUM_IRQ-32)*NUM_CPU-1:0] tgt_all,
  output logic [NUM_CPU*NUM_IRQ-1:0]   fwd_o
);
  logic [NUM_CPU*NUM_IRQ-1:0] want;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
      if (i < 32) begin : g_priv
        assign want[c*NUM_IRQ+i] = pend_all[c*NUM_IRQ+i] & en_all[c*NUM_IRQ+i];
      end else begin : g_shared
        assign want[c*NUM_IRQ+i] = pend_all[c*NUM_IRQ+i] & en_all[c*NUM_IRQ+i]
                                   & tgt_all[(i-32)*NUM_CPU+c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          fwd_o <= '0;
    else if (glob_en) fwd_o <= want;
    else              fwd_o <= '0;
  end

  p_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (fwd_o == '0));
endmodule

// File: rtl/irqdist_top.sv
module irqdist_top
  import irqdist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [CPU_ID_W-1:0]        bus_cpu,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_IRQ-33:0]        irq_shared,
  input  logic [NUM_CPU*16-1:0]      irq_local,
  output logic [NUM_CPU*NUM_IRQ-1:0] cpu_irq,
  output logic [NUM_IRQ*8-1:0]       prio_o
);
  localparam int NW  = NUM_IRQ / 32;
  localparam int NSH = NUM_IRQ - 32;
  localparam int NCW = NSH / 16;
  localparam logic [4:0] TYPE_N = 5'(NW - 1);

  area_e      area;
  view_e      view;
  logic [4:0] bword;
  logic [7:0] lword;
  logic       acc_w;
  logic       glob_en;

  assign area  = area_e'(bus_addr[9:8]);
  assign view  = view_e'(bus_addr[7:5]);
  assign bword = bus_addr[4:0];
  assign lword = bus_addr[7:0];
  assign acc_w = bus_en & bus_we;

  // write data placed at the addressed word of a full-width bit view
  logic [NUM_IRQ-1:0] wmask;
  always_comb begin
    wmask = '0;
    for (int w = 0; w < NW; w++)
      if (int'(bword) == w) wmask[w*32 +: 32] = bus_wdata;
  end

  logic bits_w;
  assign bits_w = acc_w && (area == AREA_BITS);
  logic [NUM_IRQ-1:0] en_s, en_c, pd_s, pd_c, ac_s, ac_c;
  assign en_s = (bits_w && view == VW_EN_SET) ? wmask : '0;
  assign en_c = (bits_w && view == VW_EN_CLR) ? wmask : '0;
  assign pd_s = (bits_w && view == VW_PD_SET) ? wmask : '0;
  assign pd_c = (bits_w && view == VW_PD_CLR) ? wmask : '0;
  assign ac_s = (bits_w && view == VW_AC_SET) ? wmask : '0;
  assign ac_c = (bits_w && view == VW_AC_CLR) ? wmask : '0;

  // ---------------- shared interrupts (ID 32 and up) ----------------
  logic [NSH-1:0] en_sh, pd_sh, ac_sh, prev_sh, cfg_sh, hw_sh;
  logic [NSH*NUM_CPU-1:0] tgt_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sh <= '0;
      cfg_sh  <= '0;
      tgt_sh  <= '0;
      glob_en <= 1'b0;
    end else begin
      prev_sh <= irq_shared;
      if (bits_w && view == VW_MISC && bword == 5'd0) glob_en <= bus_wdata[0];
      for (int j = 0; j < NSH; j++) begin
        if (acc_w && area == AREA_CFG && int'(lword) == (32 + j) / 16)
          cfg_sh[j] <= bus_wdata[2*(j%16)+1];
        if (acc_w && area == AREA_TGT && int'(lword) == (32 + j) / 4)
          tgt_sh[j*NUM_CPU +: NUM_CPU] <= bus_wdata[8*(j%4) +: NUM_CPU];
      end
    end
  end

  assign hw_sh = (cfg_sh & irq_shared & ~prev_sh) | (~cfg_sh & irq_shared);

  irqdist_bits #(.W(NSH)) u_en_sh (.clk(clk), .rst(rst), .set_i(en_s[NUM_IRQ-1:32]),
                                   .clr_i(en_c[NUM_IRQ-1:32]), .q(en_sh));
  irqdist_bits #(.W(NSH)) u_pd_sh (.clk(clk), .rst(rst), .set_i(pd_s[NUM_IRQ-1:32] | hw_sh),
                                   .clr_i(pd_c[NUM_IRQ-1:32]), .q(pd_sh));
  irqdist_bits #(.W(NSH)) u_ac_sh (.clk(clk), .rst(rst), .set_i(ac_s[NUM_IRQ-1:32]),
                                   .clr_i(ac_c[NUM_IRQ-1:32]), .q(ac_sh));

  // priority bytes, one per ID
  always_ff @(posedge clk) begin
    if (rst) prio_o <= '0;
    else
      for (int i = 0; i < NUM_IRQ; i++)
        if (acc_w && area == AREA_PRIO && int'(lword) == i / 4)
          prio_o[i*8 +: 8] <= bus_wdata[8*(i%4) +: 8];
  end

  // ---------------- private banks (ID 0..31, one per CPU) ----------------
  logic [NUM_CPU*32-1:0]      en_p, pd_p, ac_p;
  logic [NUM_CPU*16-1:0]      cfg_p;
  logic [NUM_CPU*NUM_IRQ-1:0] pend_all, en_all;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic        mine;
    logic [15:0] line, prev_q, cfg_q;
    logic [31:0] hw;
    assign mine = (int'(bus_cpu) == c);
    assign line = irq_local[c*16 +: 16];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= '0;
        cfg_q  <= '0;
      end else begin
        prev_q <= line;
        if (mine && acc_w && area == AREA_CFG && lword == 8'd1)
          for (int k = 0; k < 16; k++) cfg_q[k] <= bus_wdata[2*k+1];
      end
    end

    assign hw = {(cfg_q & line & ~prev_q) | (~cfg_q & line), 16'h0000};

    irqdist_bits #(.W(32)) u_en (.clk(clk), .rst(rst), .set_i(mine ? en_s[31:0] : 32'h0),
                                 .clr_i(mine ? en_c[31:0] : 32'h0), .q(en_p[c*32 +: 32]));
    irqdist_bits #(.W(32)) u_pd (.clk(clk), .rst(rst), .set_i((mine ? pd_s[31:0] : 32'h0) | hw),
                                 .clr_i(mine ? pd_c[31:0] : 32'h0), .q(pd_p[c*32 +: 32]));
    irqdist_bits #(.W(32)) u_ac (.clk(clk), .rst(rst), .set_i(mine ? ac_s[31:0] : 32'h0),
                                 .clr_i(mine ? ac_c[31:0] : 32'h0), .q(ac_p[c*32 +: 32]));

    assign cfg_p[c*16 +: 16]          = cfg_q;
    assign pend_all[c*NUM_IRQ +: NUM_IRQ] = {pd_sh, pd_p[c*32 +: 32]};
    assign en_all[c*NUM_IRQ +: NUM_IRQ]   = {en_sh, en_p[c*32 +: 32]};
  end

  irqdist_route #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_route (
    .clk(clk), .rst(rst), .glob_en(glob_en), .pend_all(pend_all),
    .en_all(en_all), .tgt_all(tgt_sh), .fwd_o(cpu_irq));

  // ---------------- read path ----------------
  logic [31:0]        en_ps, pd_ps, ac_ps, rd_c;
  logic [15:0]        cfg_ps;
  logic [7:0]         self_bit;
  logic [NUM_IRQ-1:0] sel_v;

  always_comb begin
    en_ps = '0; pd_ps = '0; ac_ps = '0; cfg_ps = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (int'(bus_cpu) == c) begin
        en_ps  = en_p[c*32 +: 32];
        pd_ps  = pd_p[c*32 +: 32];
        ac_ps  = ac_p[c*32 +: 32];
        cfg_ps = cfg_p[c*16 +: 16];
      end
    self_bit = (int'(bus_cpu) < NUM_CPU) ? (8'd1 << bus_cpu) : 8'd0;
    case (view)
      VW_EN_SET, VW_EN_CLR: sel_v = {en_sh, en_ps};
      VW_PD_SET, VW_PD_CLR: sel_v = {pd_sh, pd_ps};
      VW_AC_SET, VW_AC_CLR: sel_v = {ac_sh, ac_ps};
      default:              sel_v = '0;
    endcase
    rd_c = '0;
    case (area)
      AREA_BITS: begin
        if (view == VW_MISC) begin
          if (bword == 5'd0)      rd_c = {31'h0, glob_en};
          else if (bword == 5'd1) rd_c = {27'h0, TYPE_N};
        end else begin
          for (int w = 0; w < NW; w++)
            if (int'(bword) == w) rd_c = sel_v[w*32 +: 32];
        end
      end
      AREA_PRIO: begin
        for (int i = 0; i < NUM_IRQ; i++)
          if (int'(lword) == i / 4) rd_c[8*(i%4) +: 8] = prio_o[i*8 +: 8];
      end
      AREA_TGT: begin
        if (lword < 8'd8) rd_c = {4{self_bit}};
        for (int j = 0; j < NSH; j++)
          if (int'(lword) == (32 + j) / 4)
            rd_c[8*(j%4) +: NUM_CPU] = tgt_sh[j*NUM_CPU +: NUM_CPU];
      end
      default: begin
        if (lword == 8'd0)      rd_c = CFG_FIXED_WORD;
        else if (lword == 8'd1) rd_c = spread_edge(cfg_ps);
        else
          for (int k = 0; k < NCW; k++)
            if (int'(lword) == 2 + k) rd_c = spread_edge(cfg_sh[k*16 +: 16]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_c;
  end

  p_fwd_needs_pending_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cpu_irq & ~$past(pend_all)) == '0));
  p_level_holds_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~pd_sh & $past(irq_shared & ~cfg_sh)) == '0));
  p_local_target_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && area == AREA_TGT && lword < 8'd8 && int'(bus_cpu) < NUM_CPU)
    |=> ($countones(bus_rdata[7:0]) == 1));
endmodule

// File: tb/irqdist_top_test.sv
module irqdist_top_test;
  localparam int NI = 64;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [2:0]        bus_cpu = '0;
  logic [31:0]       bus_rdata;
  logic [NI-33:0]    irq_shared = '0;
  logic [NC*16-1:0]  irq_local = '0;
  logic [NC*NI-1:0]  cpu_irq;
  logic [NI*8-1:0]   prio_o;

  int checks = 0;
  int errors = 0;

  irqdist_top #(.NUM_IRQ(NI), .NUM_CPU(NC)) uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .irq_shared(irq_shared), .irq_local(irq_local), .cpu_irq(cpu_irq), .prio_o(prio_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_cpu = 3'(cpu); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_cpu = 3'(cpu); bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, 10'h000, v); chk("R9 ctrl reset", v, 32'h0);
    rd(0, 10'h021, v); chk("R1 enable reset", v, 32'h0);
    chk("R12 no forward at reset", {31'h0, |cpu_irq}, 32'h0);
  endtask

  task automatic t_type;
    logic [31:0] v;
    rd(0, 10'h001, v); chk("R7 type", v, 32'h1);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(0, 10'h021, 32'h5);
    rd(0, 10'h021, v); chk("R1 set view", v, 32'h5);
    rd(0, 10'h041, v); chk("R1 clear view reads", v, 32'h5);
    wr(0, 10'h041, 32'h1);
    rd(0, 10'h021, v); chk("R1 clear", v, 32'h4);
    wr(0, 10'h021, 32'h0);
    wr(0, 10'h041, 32'h0);
    rd(0, 10'h021, v); chk("R2 zeros ignored", v, 32'h4);
    wr(0, 10'h0A1, 32'h10);
    rd(0, 10'h0C1, v); chk("R1 active set", v, 32'h10);
    wr(0, 10'h0C1, 32'h10);
    rd(0, 10'h0A1, v); chk("R1 active clear", v, 32'h0);
  endtask

  task automatic t_bank;
    logic [31:0] v;
    wr(0, 10'h060, 32'h8);
    rd(0, 10'h060, v); chk("R3 own bank", v, 32'h8);
    rd(1, 10'h060, v); chk("R3 other bank", v, 32'h0);
    wr(1, 10'h020, 32'h8);
    rd(1, 10'h020, v); chk("R3 cpu1 enable", v, 32'h8);
    rd(0, 10'h020, v); chk("R3 cpu0 enable untouched", v, 32'h0);
  endtask

  task automatic t_target;
    logic [31:0] v;
    rd(1, 10'h200, v); chk("R5 local target cpu1", v, 32'h0202_0202);
    wr(0, 10'h200, 32'hFFFF_FFFF);
    rd(0, 10'h200, v); chk("R5 local target read-only", v, 32'h0101_0101);
    wr(0, 10'h208, 32'hFFFF_FFFF);
    rd(0, 10'h208, v); chk("R4 stored target bits", v, 32'h0303_0303);
  endtask

  task automatic t_config;
    logic [31:0] v;
    rd(0, 10'h300, v); chk("R6 fixed word", v, 32'hAAAA_AAAA);
    wr(0, 10'h300, 32'h0);
    rd(0, 10'h300, v); chk("R6 fixed ignores write", v, 32'hAAAA_AAAA);
    wr(0, 10'h302, 32'hFFFF_FFFF);
    rd(0, 10'h302, v); chk("R6 even bits zero", v, 32'hAAAA_AAAA);
    wr(0, 10'h302, 32'h2);
    rd(0, 10'h302, v); chk("R6 shared cfg", v, 32'h2);
    wr(0, 10'h301, 32'h8);
    rd(0, 10'h301, v); chk("R6 banked cfg cpu0", v, 32'h8);
    rd(1, 10'h301, v); chk("R6 banked cfg cpu1", v, 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(0, 10'h108, 32'h4433_2211);
    rd(1, 10'h108, v); chk("R8 priority read", v, 32'h4433_2211);
    chk("R8 priority export", {24'h0, prio_o[33*8 +: 8]}, 32'h22);
  endtask

  task automatic t_forward;
    wr(0, 10'h021, 32'h2);
    wr(0, 10'h208, 32'h0000_0200);
    wr(0, 10'h000, 32'h1);
    @(negedge clk); irq_shared[1] = 1'b1;
    idle(3);
    chk("R4 R12 routed to cpu1", {31'h0, cpu_irq[NI+33]}, 32'h1);
    chk("R4 not routed to cpu0", {31'h0, cpu_irq[33]}, 32'h0);
    wr(0, 10'h000, 32'h0);
    idle(2);
    chk("R9 gate off", {31'h0, |cpu_irq}, 32'h0);
    wr(0, 10'h000, 32'h1);
    idle(2);
    chk("R9 gate back on", {31'h0, cpu_irq[NI+33]}, 32'h1);
  endtask

  task automatic t_level;
    logic [31:0] v;
    rd(0, 10'h061, v); chk("R11 level pending", v, 32'h2);
    wr(0, 10'h081, 32'h2);
    rd(0, 10'h061, v); chk("R11 clear while high", v, 32'h2);
    @(negedge clk); irq_shared[1] = 1'b0;
    idle(1);
    rd(0, 10'h061, v); chk("R11 held after drop", v, 32'h2);
    wr(0, 10'h081, 32'h2);
    rd(0, 10'h061, v); chk("R11 clear after low", v, 32'h0);
    idle(1);
    chk("R12 forward drops", {31'h0, cpu_irq[NI+33]}, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    @(negedge clk); irq_shared[0] = 1'b1;
    idle(2);
    rd(0, 10'h061, v); chk("R10 edge sets", v, 32'h1);
    wr(0, 10'h081, 32'h1);
    idle(2);
    rd(0, 10'h061, v); chk("R10 stays clear while high", v, 32'h0);
  endtask

  task automatic t_local_line;
    logic [31:0] v;
    @(negedge clk); irq_local[1] = 1'b1;
    idle(2);
    rd(0, 10'h060, v); chk("R3 R10 local edge cpu0", v, 32'h0002_0008);
    rd(1, 10'h060, v); chk("R3 local line other cpu", v, 32'h0);
    wr(0, 10'h020, 32'h8);
    idle(2);
    chk("R12 private forward cpu0", {31'h0, cpu_irq[3]}, 32'h1);
    chk("R3 private not on cpu1", {31'h0, cpu_irq[NI+3]}, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_type();
    t_setclr();
    t_bank();
    t_target();
    t_config();
    t_priority();
    t_forward();
    t_level();
    t_edge();
    t_local_line();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule